// File: doc/BRIEF.md
# Synchronous RAM with Write Bypass

A single-clock memory block with one write port and one read port. Writes land in the storage array only on a rising clock edge while the write strobe is high; there is no level-sensitive write path. The read port is fixed at elaboration time to one of two forms: a combinational port, whose data follows the read address with no clock in the path, or a registered port, which samples the address on an edge and presents the word one cycle later.

Two settings decide what a read returns when it targets the word that is being written in the same cycle. In combinational mode, an optional forwarding path steers the incoming write data straight onto the read output. A producer and a consumer in the same cycle then see no latency, even though the array itself only changes at the next edge. In registered mode, a read-during-write option picks either the word held before the write or the word being written. Both options assume that the two ports run on the one shared clock.

The array is not cleared by reset. Only the registered read output clears, and it does so on a synchronous active-low reset.

Top module: `sbr_ram`

## Requirements
- R1: A write happens only on a rising clock edge with `wr_en` high. A cycle with `wr_en` low leaves the addressed word unchanged, whatever `wr_addr` and `wr_data` carry, and a later read shows this.
- R2: In combinational mode (`RD_MODE = RD_COMB`) with `rd_en` high and no same-address write, `rd_data` equals the stored word at `rd_addr` in the same cycle.
- R3: In combinational mode, `rd_data` is all zeros while `rd_en` is low.
- R4: In combinational mode with `BYPASS = 1`, when `rd_en` and `wr_en` are high and `rd_addr == wr_addr`, `rd_data` equals `wr_data` in that same cycle.
- R5: In combinational mode with `BYPASS = 0`, in the same collision case, `rd_data` shows the word stored before the write until the edge commits it.
- R6: In registered mode (`RD_MODE = RD_REG`), an edge with `rd_en` high and no same-address write loads `rd_data` with the stored word at the sampled `rd_addr`. The value is visible from the following cycle.
- R7: In registered mode, an edge with `rd_en` low leaves `rd_data` unchanged.
- R8: In registered mode with `RDW = RDW_OLD`, a read and a write to the same address on one edge return the value held before that write.
- R9: In registered mode with `RDW = RDW_NEW`, a read and a write to the same address on one edge return the data being written.
- R10: In registered mode, an edge with `rst_n` low clears `rd_data` to zero. Array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the registered read output |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | AW = clog2(DEPTH) | Write word address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Read data (combinational or registered by `RD_MODE`) |

## Verification
The case that matters is a read and a write that land on the same word in one cycle. The forwarding or transparency choice then competes with the plain array read. The bench provokes this with directed collisions that carry fresh data, with a write followed at once by a read of the same word, and with a long random run over a small address space. It drives four instances, one for each mode combination, with identical stimulus. A behavioural reference array judges every output on every cycle: it predicts the old word or the new word from each instance's settings.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
// Package: shared mode types for the synchronous RAM with write bypass.
// Assumes: consumers import the enums for elaboration-time parameters only.
package sbr_pkg;

    // Read port form
    typedef enum logic {
        RD_COMB = 1'b0,
        RD_REG  = 1'b1
    } rd_mode_e;

    // Registered-mode read-during-write result
    typedef enum logic {
        RDW_OLD = 1'b0,
        RDW_NEW = 1'b1
    } rdw_e;

endpackage

// File: rtl/sbr_store.sv
`timescale 1ns/1ps
// Module: sbr_store
// Storage array with one edge-triggered write port and one
// combinational read port.
// Assumes: single clock; contents are not reset; an address at or above
// DEPTH is dropped on write and reads back as zero.
module sbr_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);

    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];

    logic w_ok;
    logic r_ok;

    // Range checks on both addresses
    always_comb begin
        w_ok = ({1'b0, waddr} < LIMIT);
        r_ok = ({1'b0, raddr} < LIMIT);
    end

    // Commit a write on the rising edge only
    always_ff @(posedge clk) begin
        if (we && w_ok) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Continuous array read
    always_comb begin
        rword = r_ok ? mem_q[raddr] : '0;
    end

endmodule

// File: rtl/sbr_fwd.sv
`timescale 1ns/1ps
// Module: sbr_fwd
// Collision detection and selection between the array word and the
// write data.
// Assumes: FWD_NEW is fixed at elaboration; a collision needs the write
// strobe high and an exact full-width address match.
module sbr_fwd #(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter bit FWD_NEW = 1'b0
) (
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    input  logic [DW-1:0] rword,
    output logic [DW-1:0] word
);

    logic hit;

    // Detect a same-address write in this cycle
    always_comb begin
        hit = we && (waddr == raddr);
    end

    generate
        if (FWD_NEW) begin : g_new
            // Steer fresh write data onto the read path on a hit
            always_comb begin
                word = hit ? wdata : rword;
            end
        end else begin : g_old
            logic unused_hit;
            logic [DW-1:0] unused_wdata;
            // Array word only; write data never reaches the read path
            always_comb begin
                unused_hit   = hit;
                unused_wdata = wdata;
                word         = rword;
            end
        end
    endgenerate

endmodule

// File: rtl/sbr_outreg.sv
`timescale 1ns/1ps
// Module: sbr_outreg
// Read output register with load enable and synchronous active-low clear.
// Assumes: clear takes priority over load.
module sbr_outreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    // Clear, load or hold the read word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sbr_ram.sv
`timescale 1ns/1ps
// Module: sbr_ram (top)
// Single-clock RAM with a synchronous write port and a read port that is
// combinational or registered by RD_MODE. In combinational mode BYPASS
// forwards write data to a same-address read. In registered mode RDW
// picks the old or the new word on a same-edge collision.
// Assumes: one clock for both ports; the array has no reset.
module sbr_ram #(
    parameter int               DEPTH   = 16,
    parameter int               DW      = 8,
    parameter sbr_pkg::rd_mode_e RD_MODE = sbr_pkg::RD_REG,
    parameter sbr_pkg::rdw_e     RDW     = sbr_pkg::RDW_OLD,
    parameter bit               BYPASS  = 1'b1,
    localparam int              AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam bit FWD_NEW = (RD_MODE == sbr_pkg::RD_COMB) ? BYPASS
                                                           : (RDW == sbr_pkg::RDW_NEW);

    logic [DW-1:0] arr_word;
    logic [DW-1:0] fwd_word;

    sbr_store #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rword (arr_word)
    );

    sbr_fwd #(
        .DW      (DW),
        .AW      (AW),
        .FWD_NEW (FWD_NEW)
    ) u_fwd (
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rword (arr_word),
        .word  (fwd_word)
    );

    generate
        if (RD_MODE == sbr_pkg::RD_COMB) begin : g_comb
            logic unused_rst;
            // Gate the selected word with the read strobe
            always_comb begin
                unused_rst = rst_n;
                rd_data    = rd_en ? fwd_word : '0;
            end
        end else begin : g_reg
            sbr_outreg #(
                .DW (DW)
            ) u_outreg (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (rd_en),
                .d     (fwd_word),
                .q     (rd_data)
            );
        end
    endgenerate

endmodule

// File: rtl/sbr_ram_chk.sv
`timescale 1ns/1ps
// Module: sbr_ram_chk
// Property checker for sbr_ram, attached through bind.
// Assumes: arr_word is the array's own read of rd_addr, driven by the
// storage logic and independent of the read-path selection.
module sbr_ram_chk #(
    parameter int               DW      = 8,
    parameter int               AW      = 4,
    parameter sbr_pkg::rd_mode_e RD_MODE = sbr_pkg::RD_REG,
    parameter bit               FWD_NEW = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] arr_word
);

    logic coll;

    // Same-address read and write in this cycle
    always_comb begin
        coll = rd_en && wr_en && (rd_addr == wr_addr);
    end

    generate
        if (RD_MODE == sbr_pkg::RD_COMB) begin : g_comb
            // R3
            rd_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en |-> rd_data == '0);
            // R2
            comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && !coll) |-> rd_data == arr_word);
            if (FWD_NEW) begin : g_byp
                // R4
                bypass_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    coll |-> rd_data == wr_data);
            end else begin : g_nobyp
                // R5
                nobypass_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    coll |-> rd_data == arr_word);
            end
        end else begin : g_reg
            // R10
            rst_clear_chk: assert property (@(posedge clk)
                !rst_n |=> rd_data == '0);
            // R7
            rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en |=> $stable(rd_data));
            // R6
            reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && !coll) |=> rd_data == $past(arr_word));
            if (FWD_NEW) begin : g_new
                // R9
                rdw_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    coll |=> rd_data == $past(wr_data));
            end else begin : g_old
                // R8
                rdw_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    coll |=> rd_data == $past(arr_word));
            end
        end
    endgenerate

endmodule

bind sbr_ram sbr_ram_chk #(
    .DW      (DW),
    .AW      (AW),
    .RD_MODE (RD_MODE),
    .FWD_NEW (FWD_NEW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .arr_word (arr_word)
);

// File: tb/sbr_ram_tb.sv
`timescale 1ns/1ps
// Bench: four instances cover every mode combination and share one
// stimulus stream. A behavioural reference array predicts every output
// on every cycle.
module sbr_ram_tb;

    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [DW-1:0] wd = '0;
    logic          re = 1'b0;
    logic [AW-1:0] ra = '0;

    logic [DW-1:0] rd_comb_old, rd_comb_byp, rd_reg_old, rd_reg_new;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] exp_old = '0;
    logic [DW-1:0] exp_new = '0;
    string tag_old = "R10";
    string tag_new = "R10";
    logic [AW-1:0] last_wa = '0;

    always #2.5 clk = ~clk;

    sbr_ram #(.DEPTH(DEPTH), .DW(DW), .RD_MODE(sbr_pkg::RD_COMB), .BYPASS(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_en(re), .rd_addr(ra), .rd_data(rd_comb_old));
    sbr_ram #(.DEPTH(DEPTH), .DW(DW), .RD_MODE(sbr_pkg::RD_COMB), .BYPASS(1'b1)) u_dut_byp (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_en(re), .rd_addr(ra), .rd_data(rd_comb_byp));
    sbr_ram #(.DEPTH(DEPTH), .DW(DW), .RD_MODE(sbr_pkg::RD_REG), .RDW(sbr_pkg::RDW_OLD)) u_dut_old (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_en(re), .rd_addr(ra), .rd_data(rd_reg_old));
    sbr_ram #(.DEPTH(DEPTH), .DW(DW), .RD_MODE(sbr_pkg::RD_REG), .RDW(sbr_pkg::RDW_NEW)) u_dut_new (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_en(re), .rd_addr(ra), .rd_data(rd_reg_new));

    task automatic chk(input string tag, input string who,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check, then advance the model
    task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic e, input logic [AW-1:0] b);
        logic coll;
        logic [DW-1:0] e_old, e_byp;
        string tc;
        @(negedge clk);
        rst_n = r; we = w; wa = a; wd = d; re = e; ra = b;
        #1;
        coll = w && (a == b);
        if (chk_on) begin
            // combinational instances, same cycle
            if (!e) begin
                e_old = '0; e_byp = '0; tc = "R3";
                chk(tc, "comb", rd_comb_old, e_old);
                chk(tc, "bypass", rd_comb_byp, e_byp);
            end else if (coll) begin
                chk("R5", "comb", rd_comb_old, ref_mem[b]);
                chk("R4", "bypass", rd_comb_byp, d);
            end else begin
                tc = (b == last_wa) ? "R1" : "R2";
                chk(tc, "comb", rd_comb_old, ref_mem[b]);
                chk(tc, "bypass", rd_comb_byp, ref_mem[b]);
            end
            // registered instances, predicted at the previous edge
            chk(tag_old, "reg_old", rd_reg_old, exp_old);
            chk(tag_new, "reg_new", rd_reg_new, exp_new);
        end
        // model of the coming edge
        if (!r) begin
            exp_old = '0; exp_new = '0; tag_old = "R10"; tag_new = "R10";
        end else if (e) begin
            exp_old = ref_mem[b];
            exp_new = coll ? d : ref_mem[b];
            tag_old = coll ? "R8" : "R6";
            tag_new = coll ? "R9" : "R6";
        end else begin
            tag_old = "R7"; tag_new = "R7";
        end
        if (w) ref_mem[a] = d;
        last_wa = a;
    endtask

    initial begin
        // reset, outputs cleared (R10)
        step(1'b0, 1'b0, '0, '0, 1'b0, '0);
        chk_on = 1'b1;
        step(1'b0, 1'b0, '0, '0, 1'b1, 4'd3);
        step(1'b0, 1'b0, '0, '0, 1'b0, '0);
        // fill every word, read strobe low (R3, R7)
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b1, AW'(i), DW'(i * 7 + 3), 1'b0, '0);
        // plain reads of every word (R2, R6)
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b0, '0, '0, 1'b1, AW'(i));
        // strobe low with junk data must not write (R1)
        step(1'b1, 1'b0, 4'd6, 8'hEE, 1'b0, '0);
        step(1'b1, 1'b0, '0, '0, 1'b1, 4'd6);
        // same-edge collisions (R4, R5, R8, R9)
        step(1'b1, 1'b1, 4'd5, 8'hA5, 1'b1, 4'd5);
        step(1'b1, 1'b1, 4'd5, 8'h5A, 1'b1, 4'd5);
        step(1'b1, 1'b1, 4'd0, 8'hFF, 1'b1, 4'd0);
        step(1'b1, 1'b1, 4'd15, 8'h00, 1'b1, 4'd15);
        // write then read at once, same word (R1, R6)
        step(1'b1, 1'b1, 4'd9, 8'h3C, 1'b0, '0);
        step(1'b1, 1'b0, '0, '0, 1'b1, 4'd9);
        step(1'b1, 1'b1, 4'd9, 8'hC3, 1'b1, 4'd2);
        step(1'b1, 1'b0, '0, '0, 1'b1, 4'd9);
        // hold while the held word is rewritten (R7)
        step(1'b1, 1'b1, 4'd9, 8'h77, 1'b0, 4'd9);
        step(1'b1, 1'b0, '0, '0, 1'b0, 4'd9);
        // random mix, small address range, one reset pulse (R10)
        for (int i = 0; i < 400; i++) begin
            logic r;
            r = !(i >= 200 && i < 202);
            step(r, 1'($urandom), AW'($urandom % 4), DW'($urandom),
                 1'($urandom), AW'($urandom % 4));
        end
        step(1'b1, 1'b0, '0, '0, 1'b0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule